// File: doc/BRIEF.md
# Level-Sensed External Interrupt Aggregator

This block combines a set of external interrupt pins into one request line for a CPU interrupt controller. Each pin passes through a synchronizer. A per-pin polarity bit then decides whether the low or the high level counts as active, and a per-pin enable bit masks the pin. The block keeps no memory of past requests: a pin that returns to its inactive level removes its request at once. An interrupt handler must therefore clear the condition at its source before it returns.

All pins share one priority field. The block drives that field out continuously, next to the combined request. A priority of zero masks the request line. Software uses a small word-addressed register bus to set up the enable, polarity and priority registers and to read the live per-pin request state.

Top module: `pin_irq_aggregator`

## Requirements
- R1: After reset, all four registers read 0, `irq_req` is 0 and `irq_prio` is 0. Every pin is then disabled and set to low-level sensing.
- R2: Address 0 holds the enable register in bits 7:0, one bit per pin (bit i = pin i, 1 = enabled). It is read/write, and bits 15:8 read 0.
- R3: Address 1 holds the polarity register in bits 7:0. Bit i = 0 makes pin i active while low, and bit i = 1 makes it active while high. Bits 15:8 read 0.
- R4: Address 2 holds the 4-bit shared priority in bits 15:12, and all other bits read 0. `irq_prio` always shows this field, whether or not a request is active.
- R5: Address 3 is the status register. Bit i reads 1 exactly when pin i is enabled and its synchronized level is its active level. Disabled pins read 0.
- R6: A write to address 3 changes no register and no status bit.
- R7: A request follows the pin level. It stays asserted while the pin is active, and it drops once the pin goes inactive, with no latched state left behind.
- R8: A pin change shows up in the status register and on `irq_req` after the second rising clock edge that follows the change, and not after the first.
- R9: `irq_req` is the OR of all status bits, and it is held at 0 while the priority field is 0.
- R10: A write to the enable or polarity register affects the status bits and `irq_req` in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | External interrupt pins, asynchronous |
| bus_addr | input | 2 | Register word address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Combined interrupt request |
| irq_prio | output | 4 | Shared priority level |

## Verification
A wrong enable or polarity bit shows up in the status word and on `irq_req` in the very next cycle. A synchronizer with the wrong depth moves the first visible change of a pin by one or more cycles, so a check that samples after exactly one edge and again after exactly two edges catches it. Leftover latched state keeps `irq_req` high two cycles after the pin has gone inactive. A corrupted priority field shows up on `irq_prio` at once, and a zero field must also silence `irq_req`.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
   typedef enum logic [1:0] {
      REG_ENABLE = 2'd0,
      REG_SENSE  = 2'd1,
      REG_PRIO   = 2'd2,
      REG_STATUS = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irqa_sync.sv
module irqa_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irqa_sync: STAGES must be at least 2");
   end

   if (STAGES == 2) begin : g_two
      logic [WIDTH-1:0] meta_q, hold_q;
      logic [1:0]       warm_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
            warm_q <= '0;
         end else begin
            meta_q <= d_async;
            hold_q <= meta_q;
            if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
         end
      end
      assign q_sync = hold_q;

      AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
         (warm_q == 2'd3) |-> (q_sync == $past(d_async, 2)))
         else $error("sync latency broken"); // R8
   end else begin : g_chain
      logic [WIDTH-1:0] chain_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
         end else begin
            chain_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
         end
      end
      assign q_sync = chain_q[STAGES-1];
   end
endmodule

// File: rtl/irqa_level.sv
module irqa_level #(
   parameter int NUM_PINS = 8
) (
   input  logic [NUM_PINS-1:0] pin_sync,
   input  logic [NUM_PINS-1:0] enable,
   input  logic [NUM_PINS-1:0] sense_high,
   output logic [NUM_PINS-1:0] status
);
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic active;
      always_comb begin
         if (sense_high[i]) active = pin_sync[i];
         else               active = ~pin_sync[i];
      end
      assign status[i] = enable[i] & active;
   end
endmodule

// File: rtl/irqa_regs.sv
module irqa_regs
   import irqa_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int DATA_W   = 16,
   parameter int PRIO_W   = 4,
   parameter int PRIO_LSB = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          addr,
   input  logic                we,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  logic [NUM_PINS-1:0] status,
   output logic [NUM_PINS-1:0] enable,
   output logic [NUM_PINS-1:0] sense_high,
   output logic [PRIO_W-1:0]   prio
);
   logic [NUM_PINS-1:0] en_q, sense_q;
   logic [PRIO_W-1:0]   prio_q;
   reg_sel_e            sel;
   logic                unused_wdata;

   assign sel          = reg_sel_e'(addr);
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         sense_q <= '0;
         prio_q  <= '0;
      end else if (we) begin
         case (sel)
            REG_ENABLE: en_q    <= wdata[NUM_PINS-1:0];
            REG_SENSE:  sense_q <= wdata[NUM_PINS-1:0];
            REG_PRIO:   prio_q  <= wdata[PRIO_LSB +: PRIO_W];
            default:    ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         REG_ENABLE: rdata[NUM_PINS-1:0]     = en_q;
         REG_SENSE:  rdata[NUM_PINS-1:0]     = sense_q;
         REG_PRIO:   rdata[PRIO_LSB +: PRIO_W] = prio_q;
         REG_STATUS: rdata[NUM_PINS-1:0]     = status;
         default:    rdata = '0;
      endcase
   end

   assign enable     = en_q;
   assign sense_high = sense_q;
   assign prio       = prio_q;

   AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 2'd0) |=> (enable == $past(wdata[NUM_PINS-1:0])))
      else $error("enable write lost"); // R2
   AST_PRIO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 2'd2) |=> (prio == $past(wdata[PRIO_LSB +: PRIO_W])))
      else $error("priority write lost"); // R4
   AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 2'd3) |=> ($stable(enable) && $stable(sense_high) && $stable(prio)))
      else $error("status write changed state"); // R6
endmodule

// File: rtl/pin_irq_aggregator.sv
module pin_irq_aggregator #(
   parameter int NUM_PINS    = 8,
   parameter int DATA_W      = 16,
   parameter int PRIO_W      = 4,
   parameter int PRIO_LSB    = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [1:0]          bus_addr,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq_req,
   output logic [PRIO_W-1:0]   irq_prio
);
   localparam int PRIO_MSB = PRIO_LSB + PRIO_W - 1;

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("pin_irq_aggregator: NUM_PINS must fit in the data word");
   end
   if (PRIO_MSB >= DATA_W) begin : g_bad_prio
      $error("pin_irq_aggregator: priority field exceeds data word");
   end

   logic [NUM_PINS-1:0] pin_sync, enable, sense_high, status;
   logic [PRIO_W-1:0]   prio;

   irqa_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (pin_sync)
   );

   irqa_level #(.NUM_PINS(NUM_PINS)) u_level (
      .pin_sync   (pin_sync),
      .enable     (enable),
      .sense_high (sense_high),
      .status     (status)
   );

   irqa_regs #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W),
      .PRIO_W   (PRIO_W),
      .PRIO_LSB (PRIO_LSB)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (bus_addr),
      .we         (bus_we),
      .wdata      (bus_wdata),
      .rdata      (bus_rdata),
      .status     (status),
      .enable     (enable),
      .sense_high (sense_high),
      .prio       (prio)
   );

   assign irq_req  = (|status) && (prio != '0);
   assign irq_prio = prio;

   AST_PRIO_ZERO_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_prio == '0) |-> !irq_req)
      else $error("request with priority zero"); // R9
   AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((status & enable) != '0))
      else $error("request without enabled source"); // R5
   AST_PRIO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 2'd2) |=> (irq_prio == $past(bus_wdata[PRIO_LSB +: PRIO_W])))
      else $error("priority output stale"); // R4
endmodule

// File: tb/pin_irq_aggregator_tb.sv
module pin_irq_aggregator_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pin_in = 8'h00;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        irq_req;
   logic [3:0]  irq_prio;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pin_irq_aggregator u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_req(irq_req), .irq_prio(irq_prio)
   );

   // {enable, polarity, pins, prio, expected status, expected req}
   localparam logic [39:0] VEC [8] = '{
      40'hFF_00_00_1_FF_1,
      40'hFF_00_FF_1_00_0,
      40'hFF_FF_A5_3_A5_1,
      40'h0F_FF_FF_F_0F_1,
      40'hF0_0F_0F_7_F0_1,
      40'hFF_AA_55_2_00_0,
      40'h81_81_81_0_81_0,
      40'h3C_00_C3_9_3C_1
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      bus_we = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check("R1 reg", v, 16'h0);
      end
      check("R1 irq_req", {15'h0, irq_req}, 16'h0);
      check("R1 irq_prio", {12'h0, irq_prio}, 16'h0);
      @(negedge clk); rst_n = 1'b1;

      // table walk: R3 R5 R9
      for (int k = 0; k < 8; k++) begin
         logic [39:0] e;
         e = VEC[k];
         @(negedge clk); pin_in = e[23:16];
         wr(2'd0, {8'h00, e[39:32]});
         wr(2'd1, {8'h00, e[31:24]});
         wr(2'd2, {e[15:12], 12'h000});
         @(negedge clk);
         rd(2'd3, v);
         check("R3/R5 status", v, {8'h00, e[11:4]});
         check("R9 irq_req", {15'h0, irq_req}, {15'h0, e[0]});
      end

      // R2: enable readback, upper bits zero
      wr(2'd0, 16'hFFFF);
      @(negedge clk); rd(2'd0, v);
      check("R2 enable readback", v, 16'h00FF);
      // R3: polarity readback
      wr(2'd1, 16'hA55A);
      @(negedge clk); rd(2'd1, v);
      check("R3 polarity readback", v, 16'h005A);
      // R4: priority field only, output tracks
      wr(2'd2, 16'hFFFF);
      @(negedge clk); rd(2'd2, v);
      check("R4 prio readback", v, 16'hF000);
      check("R4 irq_prio", {12'h0, irq_prio}, 16'h000F);

      // R6: write to status is inert
      wr(2'd0, 16'h00FF); wr(2'd1, 16'h0000); wr(2'd2, 16'h5000);
      @(negedge clk); pin_in = 8'h00;
      repeat (3) @(negedge clk);
      wr(2'd3, 16'h0000);
      rd(2'd3, v); check("R6 status after write", v, 16'h00FF);
      rd(2'd0, v); check("R6 enable kept", v, 16'h00FF);
      rd(2'd1, v); check("R6 polarity kept", v, 16'h0000);
      rd(2'd2, v); check("R6 prio kept", v, 16'h5000);
      check("R6 irq_req", {15'h0, irq_req}, 16'h1);

      // R8: two-edge latency; R7: level following
      wr(2'd0, 16'h0001); wr(2'd1, 16'h0001); wr(2'd2, 16'h1000);
      @(negedge clk); pin_in = 8'h00;
      repeat (3) @(negedge clk);
      rd(2'd3, v); check("R8 idle", v, 16'h0000);
      pin_in = 8'h01;
      @(negedge clk);
      rd(2'd3, v); check("R8 after one edge", v, 16'h0000);
      check("R8 req after one edge", {15'h0, irq_req}, 16'h0);
      @(negedge clk);
      rd(2'd3, v); check("R8 after two edges", v, 16'h0001);
      check("R8 req after two edges", {15'h0, irq_req}, 16'h1);
      repeat (4) @(negedge clk);
      check("R7 held while active", {15'h0, irq_req}, 16'h1);
      pin_in = 8'h00;
      repeat (2) @(negedge clk);
      rd(2'd3, v); check("R7 status dropped", v, 16'h0000);
      check("R7 req dropped", {15'h0, irq_req}, 16'h0);

      // R10: enable and polarity writes act next cycle
      pin_in = 8'h01;
      repeat (3) @(negedge clk);
      check("R10 active before", {15'h0, irq_req}, 16'h1);
      wr(2'd0, 16'h0000);
      rd(2'd3, v); check("R10 disable status", v, 16'h0000);
      check("R10 disable req", {15'h0, irq_req}, 16'h0);
      wr(2'd0, 16'h0001);
      wr(2'd1, 16'h0000);
      rd(2'd3, v); check("R10 polarity flip", v, 16'h0000);
      // R9: zero priority masks an active source
      wr(2'd1, 16'h0001);
      wr(2'd2, 16'h0000);
      rd(2'd3, v); check("R9 source active", v, 16'h0001);
      check("R9 prio zero masks", {15'h0, irq_req}, 16'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule